// File: doc/BRIEF.md
# Dual-Slope Bridge Converter Sequencer

This block is the digital controller of a dual-slope converter that digitises a resistive sensor bridge. It integrates the amplified bridge difference for a fixed number of clocks. It then switches the analog front end to a reference whose polarity depends on the sign just integrated. It counts clocks until the comparator that watches the integrator changes state, and that count is the magnitude of the measurement.

After reset the block holds an auto-zero enable for a fixed number of cycles, then raises `ready` and waits for `start`. Each conversion ends with the integrator back at zero, so the next `start` is accepted on the very next cycle with no new auto-zero. The comparator level arrives asynchronously and passes through a two-flop synchronizer before it is used. If the comparator never flips, a count limit ends the measurement and flags a timeout.

Top module: `bridge_dual_slope_seq`

## Requirements
- R1: After reset `az_en` is 1 for exactly AZ_CYCLES cycles while both switch selects are 0, `ready` is 0 and `result_valid` is 0. After that `ready` goes to 1 and stays at 1 until the next reset.
- R2: A `start` seen in the idle state begins the fixed phase: `sw_polarity` and `sw_path` are both 0 for exactly N1 cycles.
- R3: At the end of the fixed phase, if the synchronized comparator is 1 then `sw_polarity`=1 and `sw_path`=1. If it is 0 then `sw_polarity`=0 and `sw_path`=1. Both selects return to 0 when the conversion ends.
- R4: `result_cnt` equals the number of reference-phase cycles that come before the first cycle in which the synchronized comparator differs from its sampled level. A flip that is applied to `cmp_in` in the first reference-phase cycle, after d further cycles, gives a count of d+2.
- R5: `result_neg` is 1 when the comparator was 0 at the end of the fixed phase, and 0 when it was 1.
- R6: If no flip is seen by the time the count reaches CNT_LIMIT, the conversion ends with `result_cnt`=CNT_LIMIT and `timeout`=1. A flip that is seen in the same cycle the count reaches CNT_LIMIT takes priority and gives `timeout`=0.
- R7: `result_valid` is 1 for exactly one cycle per conversion. `result_cnt`, `result_neg` and `timeout` hold their values until the next conversion ends.
- R8: `start` is ignored during auto-zero, during the fixed phase and during the reference phase.
- R9: A `start` in the cycle right after `result_valid` begins a new conversion, and `az_en` stays 0.
- R10: `sw_mode` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request |
| cmp_in | input | 1 | Asynchronous integrator comparator level |
| sw_polarity | output | 1 | Excitation polarity select (1 = reversed) |
| sw_path | output | 1 | Amplifier path select (1 = reference path) |
| sw_mode | output | 1 | Converter mode select, fixed at 1 |
| az_en | output | 1 | Auto-zero enable |
| ready | output | 1 | Auto-zero completed |
| result_cnt | output | CNT_W | Magnitude count |
| result_neg | output | 1 | Sign, 1 = negative |
| result_valid | output | 1 | One-cycle result strobe |
| timeout | output | 1 | Last conversion hit CNT_LIMIT |

## Verification
Two events can fall in the same cycle: the comparator flip becoming visible and the counter reaching CNT_LIMIT. The bench provokes this by applying the flip CNT_LIMIT-2 cycles after the reference phase begins. The result must then show CNT_LIMIT with no timeout. Applying the flip one cycle later must give CNT_LIMIT with the timeout flag set. A behavioural per-cycle model judges both cases, along with a directed check of each.

// File: rtl/bridge_dual_slope_seq.sv
`timescale 1ns/1ps
module bridge_dual_slope_seq #(
  parameter int N1        = 64,
  parameter int CNT_LIMIT = 128,
  parameter int AZ_CYCLES = 32,
  parameter int CNT_W     = $clog2(CNT_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_in,
  output logic             sw_polarity,
  output logic             sw_path,
  output logic             sw_mode,
  output logic             az_en,
  output logic             ready,
  output logic [CNT_W-1:0] result_cnt,
  output logic             result_neg,
  output logic             result_valid,
  output logic             timeout
);
  localparam int MAXV = (N1 > AZ_CYCLES) ? ((N1 > CNT_LIMIT) ? N1 : CNT_LIMIT)
                                         : ((AZ_CYCLES > CNT_LIMIT) ? AZ_CYCLES : CNT_LIMIT);
  localparam int TW = $clog2(MAXV + 1);

  typedef enum logic [1:0] {PH_AZ, PH_IDLE, PH_INT1, PH_INT2} phase_t;

  phase_t        ph;
  logic [TW-1:0] tmr;
  logic          sy1, sy2, pol;
  logic          flipped;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= 1'b0;
      sy2 <= 1'b0;
    end else begin
      sy1 <= cmp_in;
      sy2 <= sy1;
    end

  assign flipped = (sy2 != pol);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph           <= PH_AZ;
      tmr          <= '0;
      pol          <= 1'b0;
      result_cnt   <= '0;
      result_neg   <= 1'b0;
      result_valid <= 1'b0;
      timeout      <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      case (ph)
        PH_AZ:
          if (tmr == TW'(AZ_CYCLES - 1)) begin
            ph  <= PH_IDLE;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        PH_IDLE:
          if (start) begin
            ph  <= PH_INT1;
            tmr <= '0;
          end
        PH_INT1:
          if (tmr == TW'(N1 - 1)) begin
            ph  <= PH_INT2;
            pol <= sy2;
            tmr <= '0;
          end else tmr <= tmr + 1'b1;
        PH_INT2:
          if (flipped || tmr == TW'(CNT_LIMIT)) begin
            ph           <= PH_IDLE;
            result_cnt   <= CNT_W'(tmr);
            result_neg   <= ~pol;
            timeout      <= ~flipped;
            result_valid <= 1'b1;
          end else tmr <= tmr + 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end

  assign az_en       = (ph == PH_AZ);
  assign ready       = (ph != PH_AZ);
  assign sw_path     = (ph == PH_INT2);
  assign sw_polarity = (ph == PH_INT2) && pol;
  assign sw_mode     = 1'b1;

  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  assert_az_switches_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    az_en |-> (!sw_path && !sw_polarity && !result_valid));
  assert_ref_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_path) |-> (sw_polarity == $past(sy2)));
  assert_timeout_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && timeout) |-> (result_cnt == CNT_W'(CNT_LIMIT)));
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(result_cnt) && $stable(result_neg) && $stable(timeout)));
  assert_path_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_path) |-> result_valid);
endmodule

// File: tb/bridge_dual_slope_seq_test.sv
`timescale 1ns/1ps
module bridge_dual_slope_seq_test;
  localparam int N1 = 8, LIM = 16, AZ = 5;
  localparam int CW = $clog2(LIM + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp_in = 1'b0;
  logic sw_polarity, sw_path, sw_mode, az_en, ready, result_neg, result_valid, timeout;
  logic [CW-1:0] result_cnt;

  int tests = 0, fails = 0;
  bit finished = 0;

  bridge_dual_slope_seq #(.N1(N1), .CNT_LIMIT(LIM), .AZ_CYCLES(AZ)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_in(cmp_in),
    .sw_polarity(sw_polarity), .sw_path(sw_path), .sw_mode(sw_mode),
    .az_en(az_en), .ready(ready), .result_cnt(result_cnt), .result_neg(result_neg),
    .result_valid(result_valid), .timeout(timeout));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference: 0 autozero, 1 idle, 2 fixed phase, 3 reference phase
  int m_phase = 0, m_cnt = 0, m_out = 0;
  bit m_pol = 0, m_neg = 0, m_to = 0, m_valid = 0;
  bit hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_out = 0; m_pol = 0; m_neg = 0; m_to = 0; m_valid = 0;
      hist.delete();
    end else begin
      bit seen;
      seen = (hist.size() >= 2) ? hist[hist.size()-2] : 1'b0;
      hist.push_back(cmp_in);
      if (hist.size() > 2) void'(hist.pop_front());
      m_valid = 0;
      if (m_phase == 0) begin
        m_cnt++;
        if (m_cnt == AZ) begin m_phase = 1; m_cnt = 0; end
      end else if (m_phase == 1) begin
        if (start) begin m_phase = 2; m_cnt = 0; end
      end else if (m_phase == 2) begin
        m_cnt++;
        if (m_cnt == N1) begin m_phase = 3; m_pol = seen; m_cnt = 0; end
      end else begin
        if (seen != m_pol || m_cnt == LIM) begin
          m_out = m_cnt; m_neg = !m_pol; m_to = (seen == m_pol); m_valid = 1; m_phase = 1;
        end else m_cnt++;
      end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R1 az_en", az_en, m_phase == 0);
    chk("R1 ready", ready, m_phase != 0);
    chk("R3 sw_path", sw_path, m_phase == 3);
    chk("R3 sw_polarity", sw_polarity, (m_phase == 3) && m_pol);
    chk("R10 sw_mode", sw_mode, 1);
    chk("R7 result_valid", result_valid, m_valid);
    chk("R4 result_cnt", result_cnt, m_out);
    chk("R5 result_neg", result_neg, m_neg);
    chk("R6 timeout", timeout, m_to);
  end

  task automatic conv(input bit posv, input int d, input bit noflip,
                      output int cnt, output int neg, output int to);
    int n, g;
    cmp_in = posv;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!sw_path && n < 100) begin n++; @(negedge clk); end
    chk("R2 fixed phase length", n, N1);
    chk("R3 polarity select", sw_polarity, posv);
    start = 1'b1;                       // R8: request while busy
    @(negedge clk);
    start = 1'b0;
    if (!noflip) begin
      repeat (d - 1) @(negedge clk);
      cmp_in = !posv;
    end
    g = 0;
    while (!result_valid && g < 100) begin g++; @(negedge clk); end
    cnt = result_cnt; neg = result_neg; to = timeout;
  endtask

  initial begin
    int c, ng, t;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", result_valid, 0);
    chk("R1 reset path", sw_path, 0);
    chk("R1 reset ready", ready, 0);
    rst_n = 1'b1;
    start = 1'b1;                        // R8: ignored during auto-zero
    c = 0;
    while (az_en && c < 100) begin c++; @(negedge clk); start = 1'b0; end
    chk("R1 auto-zero length", c, AZ);
    chk("R1 ready after auto-zero", ready, 1);

    conv(1'b1, 3, 1'b0, c, ng, t);
    chk("R4 count d+2", c, 5);
    chk("R5 positive sign", ng, 0);
    @(negedge clk);
    chk("R7 valid one cycle", result_valid, 0);
    chk("R7 count held", result_cnt, 5);

    conv(1'b0, 1, 1'b0, c, ng, t);
    chk("R4 count d+2 negative", c, 3);
    chk("R5 negative sign", ng, 1);
    chk("R9 no auto-zero", az_en, 0);
    conv(1'b1, 6, 1'b0, c, ng, t);      // R9: start right after valid
    chk("R9 back-to-back count", c, 8);

    conv(1'b0, 0, 1'b1, c, ng, t);
    chk("R6 timeout flag", t, 1);
    chk("R6 saturated count", c, LIM);

    conv(1'b1, LIM - 2, 1'b0, c, ng, t);
    chk("R6 flip at limit wins", t, 0);
    chk("R6 flip at limit count", c, LIM);

    conv(1'b0, LIM - 1, 1'b0, c, ng, t);
    chk("R6 flip after limit", t, 1);
    chk("R6 flip after limit count", c, LIM);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule